// File: doc/BRIEF.md
# Bit-Slip Word Aligner

This block sits behind a deserializer that delivers 8-bit parallel words with an arbitrary word boundary. A controller outside the block watches the output and, while the boundary is wrong, pulses a slip request. Each rising edge of that request moves the word boundary by one bit. The block keeps two words of received bits and takes each registered output byte from a window over them. The slip offset positions the window. It counts up by one per slip and returns to zero after eight positions.

A programmable 16-bit alignment pattern is compared every cycle with the two most recent output words. The newer word is placed in the upper byte for this comparison. When they match, a detect flag is high for that cycle. The external controller can use the flag to stop slipping.

Top module: `slip_aligner`

## Requirements
- R1: One 8-bit word is accepted and one 8-bit registered word is produced per clock. With offset zero, the word driven before clock edge t appears on `dataOut` after edge t+1.
- R2: A rising edge of `slipIn`, sampled at edge t, advances the offset by one. The new offset applies to the word presented after edge t+1.
- R3: While `slipIn` stays high for several cycles, only the first sampled cycle advances the offset.
- R4: At offset k, the output word is bits k+7 down to k of the 16-bit history {older input word, newer input word}. Each slip therefore moves one earlier-received bit into the MSB. A steady input of 8'hF0 gives 8'h78, 8'h3C, 8'h1E, 8'h0F, 8'h87, 8'hC3 and 8'hE1 at offsets 1 to 7.
- R5: The offset wraps from 7 back to 0 on the next slip.
- R6: `patternHit` is high in the cycle in which {newest output word, previous output word} equals `alignPattern`.
- R7: `patternHit` is low in every cycle whose output word pair does not match. A single matching pair gives a one-cycle pulse.
- R8: If the match holds again on the next word pair, `patternHit` stays high for that cycle as well.
- R9: A synchronous active-high `rst` clears the offset, the history, `dataOut` and `patternHit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| slipIn | input | 1 | Slip request; each rising edge moves the boundary by one bit |
| alignPattern | input | 16 | Pattern to find; upper byte is the newer word; held static |
| dataIn | input | 8 | Word from the deserializer |
| dataOut | output | 8 | Realigned word (registered) |
| patternHit | output | 1 | High for a cycle whose output word pair matches the pattern |

## Verification
A steady 8'hF0 stream is walked through all eight offsets, including the wrap. Each offset produces a different byte, so an off-by-one in the window or a missed or doubled slip shows up at once. The same walk crosses from 8'h1E to 8'h0F, which must give exactly one detect pulse. A stream of 8'h01 followed by 8'h80 at offset 1 checks the direction of the window, because only the correct word order yields 8'hC0. A pattern equal to the steady stream checks that the detect flag repeats on consecutive cycles. A reset after slipping checks that the offset returns to zero.

// File: rtl/slip_aligner_pkg.sv
package slip_aligner_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic slipStep;   // advance the window by one bit this cycle
  } align_ctrl_t;
endpackage

// File: rtl/slip_aligner_ctrl.sv
module slip_aligner_ctrl
  import slip_aligner_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        slipIn,
  output align_ctrl_t ctrl
);
  logic slipQ;

  always_ff @(posedge clk) begin
    if (rst) slipQ <= 1'b0;
    else     slipQ <= slipIn;
  end

  // only a low-to-high transition requests a step
  always_comb begin
    ctrl          = '0;
    ctrl.slipStep = slipIn & ~slipQ;
  end
endmodule

// File: rtl/slip_aligner_dp.sv
module slip_aligner_dp
  import slip_aligner_pkg::*;
#(
  parameter int WORD_W = 8,
  localparam int HIST_W = 2 * WORD_W,
  localparam int OFF_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  align_ctrl_t       ctrl,
  input  logic [HIST_W-1:0] alignPattern,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              patternHit
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORD_W - 1);

  logic [HIST_W-1:0] histQ;      // {older word, newer word}
  logic [OFF_W-1:0]  offsetQ;
  logic [OFF_W-1:0]  offsetNext;
  logic [WORD_W-1:0] outQ;
  logic              hitQ;
  logic [WORD_W-1:0] cand [WORD_W];
  logic [WORD_W-1:0] windowWord;

  // one candidate word per offset position
  for (genvar k = 0; k < WORD_W; k++) begin : g_win
    assign cand[k] = histQ[k +: WORD_W];
  end

  assign windowWord = cand[offsetQ];
  assign offsetNext = (offsetQ == LAST_OFF) ? '0 : offsetQ + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      histQ   <= '0;
      offsetQ <= '0;
      outQ    <= '0;
      hitQ    <= 1'b0;
    end else begin
      histQ <= {histQ[WORD_W-1:0], dataIn};
      outQ  <= windowWord;
      hitQ  <= ({windowWord, outQ} == alignPattern);
      if (ctrl.slipStep) offsetQ <= offsetNext;
    end
  end

  assign dataOut    = outQ;
  assign patternHit = hitQ;
endmodule

// File: rtl/slip_aligner.sv
module slip_aligner
  import slip_aligner_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  slipIn,
  input  logic [2*WORD_W-1:0]   alignPattern,
  input  logic [WORD_W-1:0]     dataIn,
  output logic [WORD_W-1:0]     dataOut,
  output logic                  patternHit
);
  align_ctrl_t ctrl;

  slip_aligner_ctrl u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .slipIn (slipIn),
    .ctrl   (ctrl)
  );

  slip_aligner_dp #(.WORD_W(WORD_W)) u_dp (
    .clk          (clk),
    .rst          (rst),
    .ctrl         (ctrl),
    .alignPattern (alignPattern),
    .dataIn       (dataIn),
    .dataOut      (dataOut),
    .patternHit   (patternHit)
  );
endmodule

// File: rtl/slip_aligner_checker.sv
module slip_aligner_checker #(
  parameter int WORD_W = 8,
  localparam int OFF_W = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                slipIn,
  input logic [2*WORD_W-1:0] alignPattern,
  input logic [WORD_W-1:0]   dataOut,
  input logic                patternHit,
  input logic [OFF_W-1:0]    offset
);
  localparam logic [OFF_W-1:0] LAST_OFF = OFF_W'(WORD_W - 1);

  p_hit_match_r6: assert property (@(posedge clk) disable iff (rst)
    patternHit |-> ({dataOut, $past(dataOut)} == alignPattern));

  p_no_false_hit_r7: assert property (@(posedge clk) disable iff (rst)
    ({dataOut, $past(dataOut)} != alignPattern) |-> !patternHit);

  p_rise_steps_r2: assert property (@(posedge clk) disable iff (rst)
    (slipIn && !$past(slipIn) && !$past(rst) && offset != LAST_OFF)
      |=> (offset == $past(offset) + 1'b1));

  p_hold_no_step_r3: assert property (@(posedge clk) disable iff (rst)
    (slipIn && $past(slipIn) && !$past(rst)) |=> $stable(offset));

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (slipIn && !$past(slipIn) && !$past(rst) && offset == LAST_OFF)
      |=> (offset == '0));

  p_reset_clear_r9: assert property (@(posedge clk)
    $past(rst) |-> (dataOut == '0 && !patternHit && offset == '0));
endmodule

bind slip_aligner slip_aligner_checker #(.WORD_W(WORD_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .slipIn       (slipIn),
  .alignPattern (alignPattern),
  .dataOut      (dataOut),
  .patternHit   (patternHit),
  .offset       (u_dp.offsetQ)
);

// File: tb/slip_aligner_bench.sv
module slip_aligner_bench;
  localparam int W = 8;
  localparam logic [15:0] PAT_MAIN = 16'b0000111100011110;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         slipIn = 1'b0;
  logic [15:0]  alignPattern = PAT_MAIN;
  logic [W-1:0] dataIn = '0;
  logic [W-1:0] dataOut;
  logic         patternHit;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;   // 250 MHz

  slip_aligner #(.WORD_W(W)) u_slip_aligner (
    .clk(clk), .rst(rst), .slipIn(slipIn), .alignPattern(alignPattern),
    .dataIn(dataIn), .dataOut(dataOut), .patternHit(patternHit)
  );

  // {slip level, expected dataOut, expected hit}; input stays 8'hF0
  localparam logic [9:0] VEC [0:19] = '{
    {1'b0, 8'hF0, 1'b0}, {1'b1, 8'hF0, 1'b0}, {1'b1, 8'h78, 1'b0},
    {1'b0, 8'h78, 1'b0}, {1'b1, 8'h78, 1'b0}, {1'b0, 8'h3C, 1'b0},
    {1'b1, 8'h3C, 1'b0}, {1'b0, 8'h1E, 1'b0}, {1'b1, 8'h1E, 1'b0},
    {1'b1, 8'h0F, 1'b1}, {1'b0, 8'h0F, 1'b0}, {1'b1, 8'h0F, 1'b0},
    {1'b0, 8'h87, 1'b0}, {1'b1, 8'h87, 1'b0}, {1'b0, 8'hC3, 1'b0},
    {1'b1, 8'hC3, 1'b0}, {1'b0, 8'hE1, 1'b0}, {1'b1, 8'hE1, 1'b0},
    {1'b0, 8'hF0, 1'b0}, {1'b0, 8'hF0, 1'b0}
  };

  task automatic check(input string req, input logic [W:0] act, input logic [W:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // apply inputs, let one edge pass, sample 1 ns later
  task automatic step(input logic s, input logic [W-1:0] d);
    slipIn = s;
    dataIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic doReset(input logic [15:0] pat);
    rst = 1'b1;
    slipIn = 1'b0;
    dataIn = '0;
    alignPattern = pat;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  initial begin
    @(posedge clk);
    #1;
    doReset(PAT_MAIN);
    // R9: reset state
    check("R9 reset state", {patternHit, dataOut}, {1'b0, 8'h00});

    // warm-up: fill history
    step(1'b0, 8'hF0);
    step(1'b0, 8'hF0);
    // R1: offset zero passes the word through
    check("R1 passthrough", {1'b0, dataOut}, {1'b0, 8'hF0});

    // R2 R3 R4 R5 R6 R7: walk every offset with a steady stream
    for (int i = 0; i < 20; i++) begin
      step(VEC[i][9], 8'hF0);
      check("R4 window word (R2 R3 R5)", {1'b0, dataOut}, {1'b0, VEC[i][8:1]});
      check("R6 R7 detect", {{W{1'b0}}, patternHit}, {{W{1'b0}}, VEC[i][0]});
    end

    // R8: pattern equal to the steady stream repeats the hit
    doReset(16'hF0F0);
    step(1'b0, 8'hF0);
    step(1'b0, 8'hF0);
    check("R8 no hit before pair", {{W{1'b0}}, patternHit}, '0);
    step(1'b0, 8'hF0);
    check("R8 hit first pair", {{W{1'b0}}, patternHit}, {{W{1'b0}}, 1'b1});
    step(1'b0, 8'hF0);
    check("R8 hit repeated", {{W{1'b0}}, patternHit}, {{W{1'b0}}, 1'b1});

    // R4: bit order across the word boundary at offset 1
    doReset(PAT_MAIN);
    step(1'b1, 8'h01);
    step(1'b0, 8'h80);
    check("R4 order first", {1'b0, dataOut}, {1'b0, 8'h00});
    step(1'b0, 8'h00);
    check("R4 earlier bit to MSB", {1'b0, dataOut}, {1'b0, 8'hC0});

    // R9: reset returns the offset to zero
    doReset(PAT_MAIN);
    step(1'b0, 8'hF0);
    step(1'b0, 8'hF0);
    check("R9 offset cleared", {1'b0, dataOut}, {1'b0, 8'hF0});

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule